// File: doc/BRIEF.md
# Two-Bank Register File Address Decoder

This block decodes data-memory accesses for a small processor core whose register file is split into two banks. The instruction supplies a 7-bit direct offset, and a bank-select bit from core state chooses which bank the offset lands in. Together they form an 8-bit effective address, with the bank bit as its most significant bit. The decoder then sends the access to one of three places: the special-function register port, the on-block general-purpose RAM, or an unimplemented hole.

The low part of each bank is a window of special-function registers. Those registers live outside this block. When an access falls in that window, the block raises a select, passes on the register index, and returns whatever the external register port drives. General-purpose RAM exists only in the upper half of bank 0. The top sixteen locations of bank 1 reach the same RAM cells as the top sixteen of bank 0, so those variables can be used without changing banks. Every other location reads zero and ignores writes.

RAM writes take effect on the rising clock edge while write enable is high. Reads are combinational from the stored contents. Reset clears the RAM when the reset variant is selected, which is the default.

Top module: `bankreg_file`

## Requirements
- R1: When the offset is below 20h, `sfr_sel_o` is 1 and `sfr_addr_o` equals offset bits [4:0], in either bank. At any other offset, `sfr_sel_o` is 0 and `sfr_addr_o` is 0.
- R2: While `sfr_sel_o` is 1, `rdata_o` equals `sfr_rdata_i` in the same cycle.
- R3: With bank 0 and an offset in 40h-7Fh, a write with `we_i`=1 stores `wdata_i` at the clock edge. The same location then reads back that value.
- R4: With bank 1 and an offset in 70h-7Fh (effective F0h-FFh), an access reaches the same cell as bank 0 at the same offset. This holds for both reads and writes.
- R5: Effective addresses 20h-3Fh and A0h-EFh read as zero.
- R6: A write to an effective address in 20h-3Fh or A0h-EFh leaves every RAM cell unchanged.
- R7: An access with `we_i`=0 changes no RAM cell.
- R8: A write in the special-function window of either bank leaves every RAM cell unchanged.
- R9: After reset, every RAM location reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| addr_i | input | 7 | Direct offset from the instruction |
| bank_i | input | 1 | Bank select, becomes effective address bit 7 |
| we_i | input | 1 | Write enable |
| wdata_i | input | 8 | Write data |
| sfr_rdata_i | input | 8 | Read data returned by the external special-function register port |
| rdata_o | output | 8 | Read data for the current access |
| sfr_sel_o | output | 1 | Access falls in the special-function window |
| sfr_addr_o | output | 5 | Special-function register index |

## Verification
A wrong region decision shows at once on `sfr_sel_o` or `rdata_o`. It appears in the same cycle the offending address is presented, because the decode and the read path are combinational. A corrupted RAM cell or a misrouted write stays hidden until that cell is read again. For that reason the bench sweeps all sixty-four cells, through both bank aliases where they exist, after each phase of stimulus, so a stray write is caught within one sweep. The reference model is compared on every access: select, index and read data.

// File: rtl/bankreg_pkg.sv
package bankreg_pkg;

   typedef enum logic [1:0] {
      REGION_SFR    = 2'd0,
      REGION_GPR    = 2'd1,
      REGION_MIRROR = 2'd2,
      REGION_NONE   = 2'd3
   } region_e;

   function automatic bit region_is_ram(region_e r);
      return (r == REGION_GPR) || (r == REGION_MIRROR);
   endfunction

endpackage

// File: rtl/bankreg_decode.sv
module bankreg_decode
   import bankreg_pkg::*;
#(
   parameter int OFS_W       = 7,
   parameter int SFR_SPAN    = 32,
   parameter int GPR_LO      = 64,
   parameter int GPR_DEPTH   = 64,
   parameter int MIRROR_SPAN = 16,
   parameter int IDX_W       = $clog2(GPR_DEPTH),
   parameter int SFR_AW      = $clog2(SFR_SPAN)
) (
   input  logic              bank_i,
   input  logic [OFS_W-1:0]  ofs_i,
   output region_e           region_o,
   output logic [IDX_W-1:0]  idx_o,
   output logic              sfr_sel_o,
   output logic [SFR_AW-1:0] sfr_addr_o
);

   localparam int BANK_SIZE = 1 << OFS_W;
   localparam int GPR_HI    = GPR_LO + GPR_DEPTH;
   localparam int MIRROR_LO = BANK_SIZE - MIRROR_SPAN;
   localparam int XW        = OFS_W + 1;

   if (GPR_HI > BANK_SIZE) begin : g_bad_gpr
      $error("general-purpose range exceeds the bank");
   end
   if (MIRROR_LO < GPR_LO) begin : g_bad_mirror
      $error("mirror window must lie over general-purpose RAM");
   end
   if (SFR_SPAN > GPR_LO) begin : g_bad_sfr
      $error("special-function window overlaps RAM");
   end
   if ((1 << SFR_AW) != SFR_SPAN) begin : g_bad_sfr_span
      $error("special-function span must be a power of two");
   end

   logic [XW-1:0] ofs_x;
   logic          in_sfr, in_gpr, in_mirror;

   assign ofs_x     = {1'b0, ofs_i};
   assign in_sfr    = ofs_x < XW'(SFR_SPAN);
   assign in_gpr    = !bank_i && (ofs_x >= XW'(GPR_LO)) && (ofs_x < XW'(GPR_HI));
   assign in_mirror = bank_i && (ofs_x >= XW'(MIRROR_LO));

   always_comb begin
      if (in_sfr)         region_o = REGION_SFR;
      else if (in_gpr)    region_o = REGION_GPR;
      else if (in_mirror) region_o = REGION_MIRROR;
      else                region_o = REGION_NONE;
   end

   // The mirror uses the same in-bank offset as bank 0, so one subtraction serves both.
   assign idx_o      = IDX_W'(ofs_x - XW'(GPR_LO));
   assign sfr_sel_o  = in_sfr;
   assign sfr_addr_o = in_sfr ? ofs_i[SFR_AW-1:0] : '0;

endmodule

// File: rtl/bankreg_store.sv
module bankreg_store #(
   parameter int DATA_W    = 8,
   parameter int DEPTH     = 64,
   parameter bit RESET_RAM = 1'b1,
   parameter int IDX_W     = $clog2(DEPTH)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en_i,
   input  logic [IDX_W-1:0]  wr_idx_i,
   input  logic [DATA_W-1:0] wr_data_i,
   input  logic [IDX_W-1:0]  rd_idx_i,
   output logic [DATA_W-1:0] rd_data_o
);

   if ((1 << IDX_W) != DEPTH) begin : g_bad_depth
      $error("storage depth must be a power of two");
   end
   if (DATA_W < 1) begin : g_bad_width
      $error("data width must be positive");
   end

   logic [DATA_W-1:0] mem_q [DEPTH];

   if (RESET_RAM) begin : g_reset_ram
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) mem_q[i] <= '0;
         end else if (wr_en_i) begin
            mem_q[wr_idx_i] <= wr_data_i;
         end
      end
   end else begin : g_plain_ram
      always_ff @(posedge clk) begin
         if (wr_en_i) mem_q[wr_idx_i] <= wr_data_i;
      end
   end

   assign rd_data_o = mem_q[rd_idx_i];

   assert_write_lands_R3 : assert property (@(posedge clk) disable iff (!rst_n)
      wr_en_i |=> mem_q[$past(wr_idx_i)] == $past(wr_data_i));

endmodule

// File: rtl/bankreg_file.sv
module bankreg_file
   import bankreg_pkg::*;
#(
   parameter int OFS_W       = 7,
   parameter int DATA_W      = 8,
   parameter int SFR_SPAN    = 32,
   parameter int GPR_LO      = 64,
   parameter int GPR_DEPTH   = 64,
   parameter int MIRROR_SPAN = 16,
   parameter bit RESET_RAM   = 1'b1,
   localparam int SFR_AW     = $clog2(SFR_SPAN)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [OFS_W-1:0]  addr_i,
   input  logic              bank_i,
   input  logic              we_i,
   input  logic [DATA_W-1:0] wdata_i,
   input  logic [DATA_W-1:0] sfr_rdata_i,
   output logic [DATA_W-1:0] rdata_o,
   output logic              sfr_sel_o,
   output logic [SFR_AW-1:0] sfr_addr_o
);

   localparam int IDX_W = $clog2(GPR_DEPTH);

   region_e           region;
   logic [IDX_W-1:0]  ram_idx;
   logic              store_we;
   logic [DATA_W-1:0] ram_rdata;

   bankreg_decode #(
      .OFS_W       (OFS_W),
      .SFR_SPAN    (SFR_SPAN),
      .GPR_LO      (GPR_LO),
      .GPR_DEPTH   (GPR_DEPTH),
      .MIRROR_SPAN (MIRROR_SPAN),
      .IDX_W       (IDX_W),
      .SFR_AW      (SFR_AW)
   ) decode_i (
      .bank_i     (bank_i),
      .ofs_i      (addr_i),
      .region_o   (region),
      .idx_o      (ram_idx),
      .sfr_sel_o  (sfr_sel_o),
      .sfr_addr_o (sfr_addr_o)
   );

   assign store_we = we_i && region_is_ram(region);

   bankreg_store #(
      .DATA_W    (DATA_W),
      .DEPTH     (GPR_DEPTH),
      .RESET_RAM (RESET_RAM),
      .IDX_W     (IDX_W)
   ) store_i (
      .clk       (clk),
      .rst_n     (rst_n),
      .wr_en_i   (store_we),
      .wr_idx_i  (ram_idx),
      .wr_data_i (wdata_i),
      .rd_idx_i  (ram_idx),
      .rd_data_o (ram_rdata)
   );

   always_comb begin
      unique case (region)
         REGION_SFR:                rdata_o = sfr_rdata_i;
         REGION_GPR, REGION_MIRROR: rdata_o = ram_rdata;
         default:                   rdata_o = '0;
      endcase
   end

   assert_sfr_index_R1 : assert property (@(posedge clk) disable iff (!rst_n)
      sfr_sel_o |-> (sfr_addr_o == addr_i[SFR_AW-1:0]));
   assert_sfr_data_R2 : assert property (@(posedge clk) disable iff (!rst_n)
      sfr_sel_o |-> (rdata_o == sfr_rdata_i));
   assert_hole_reads_zero_R5 : assert property (@(posedge clk) disable iff (!rst_n)
      (region == REGION_NONE) |-> (rdata_o == '0));
   assert_hole_no_write_R6 : assert property (@(posedge clk) disable iff (!rst_n)
      (region == REGION_NONE) |-> !store_we);
   assert_idle_no_write_R7 : assert property (@(posedge clk) disable iff (!rst_n)
      !we_i |-> !store_we);
   assert_sfr_no_write_R8 : assert property (@(posedge clk) disable iff (!rst_n)
      sfr_sel_o |-> !store_we);

endmodule

// File: tb/bankreg_file_tb_top.sv
`timescale 1ns/1ps
module bankreg_file_tb_top;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic [6:0] addr_i = '0;
   logic       bank_i = 1'b0;
   logic       we_i = 1'b0;
   logic [7:0] wdata_i = '0;
   logic [7:0] sfr_rdata_i = '0;
   logic [7:0] rdata_o;
   logic       sfr_sel_o;
   logic [4:0] sfr_addr_o;

   int checks = 0;
   int fails  = 0;
   int model [64];

   always #10 clk = ~clk;

   bankreg_file dut_i (
      .clk         (clk),
      .rst_n       (rst_n),
      .addr_i      (addr_i),
      .bank_i      (bank_i),
      .we_i        (we_i),
      .wdata_i     (wdata_i),
      .sfr_rdata_i (sfr_rdata_i),
      .rdata_o     (rdata_o),
      .sfr_sel_o   (sfr_sel_o),
      .sfr_addr_o  (sfr_addr_o)
   );

   // kind: 0 special window, 1 RAM, 2 hole; idx is the RAM cell
   function automatic void classify(input logic b, input logic [6:0] a,
                                    output int kind, output int idx);
      int ea;
      ea = (b ? 128 : 0) + int'(a);
      idx = 0;
      if (a < 7'h20) kind = 0;
      else if (ea >= 'h40 && ea <= 'h7F) begin kind = 1; idx = ea - 'h40; end
      else if (ea >= 'hF0) begin kind = 1; idx = ea - 'hF0 + 'h30; end
      else kind = 2;
   endfunction

   task automatic check(input string tag, input int act, input int exp, input string what);
      checks++;
      if (act != exp) begin
         fails++;
         $display("FAIL %s %s actual=%0h expected=%0h (bank=%0d ofs=%0h)",
                  tag, what, act, exp, bank_i, addr_i);
      end
   endtask

   task automatic step(input logic b, input logic [6:0] a, input logic w,
                       input logic [7:0] d, input logic [7:0] s, input string tag);
      int kind, idx, exp_rd;
      @(negedge clk);
      bank_i = b; addr_i = a; we_i = w; wdata_i = d; sfr_rdata_i = s;
      #1;
      classify(b, a, kind, idx);
      exp_rd = (kind == 0) ? int'(s) : (kind == 1) ? model[idx] : 0;
      check(tag, int'(sfr_sel_o), (kind == 0) ? 1 : 0, "sfr_sel R1");
      check(tag, int'(sfr_addr_o), (kind == 0) ? int'(a[4:0]) : 0, "sfr_addr R1");
      check(tag, int'(rdata_o), exp_rd, "rdata");
      if (w && kind == 1) model[idx] = int'(d);
   endtask

   task automatic sweep(input string tag);
      for (int i = 'h40; i <= 'h7F; i++) step(1'b0, 7'(i), 1'b0, 8'hA5, 8'h3C, tag);
      for (int i = 'h70; i <= 'h7F; i++) step(1'b1, 7'(i), 1'b0, 8'h5A, 8'hC3, tag);
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      fails++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", checks - fails, checks + 1);
      $finish;
   end

   initial begin
      for (int i = 0; i < 64; i++) model[i] = 0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;

      // R9: cleared after reset
      sweep("R9");

      // R3: fill bank 0 RAM with a pattern
      for (int i = 'h40; i <= 'h7F; i++) step(1'b0, 7'(i), 1'b1, 8'(i * 7 + 3), 8'h00, "R3");
      sweep("R3");

      // R4: write through bank 1 alias, read back through bank 0
      for (int i = 'h70; i <= 'h7F; i++) step(1'b1, 7'(i), 1'b1, 8'(8'hE0 ^ i), 8'h00, "R4");
      for (int i = 'h70; i <= 'h7F; i++) step(1'b0, 7'(i), 1'b0, 8'h00, 8'h00, "R4");
      for (int i = 'h70; i <= 'h7F; i += 3) step(1'b0, 7'(i), 1'b1, 8'(i + 9), 8'h00, "R4");
      sweep("R4");

      // R1, R2, R8: special window in both banks with writes
      for (int i = 0; i < 32; i++) begin
         step(1'b0, 7'(i), 1'b1, 8'hFF, 8'(i * 11), "R2");
         step(1'b1, 7'(i), 1'b1, 8'h00, 8'(255 - i), "R2");
      end
      sweep("R8");

      // R5, R6: holes in both banks, writes ignored
      for (int i = 'h20; i <= 'h3F; i++) step(1'b0, 7'(i), 1'b1, 8'h77, 8'h99, "R5");
      for (int i = 'h20; i <= 'h6F; i++) step(1'b1, 7'(i), 1'b1, 8'h66, 8'h99, "R5");
      sweep("R6");

      // R7: no write enable, data changes
      for (int i = 0; i < 128; i++) step(i[0], 7'(i), 1'b0, 8'(~i), 8'(i), "R7");
      sweep("R7");

      // mixed random traffic
      for (int i = 0; i < 2000; i++)
         step(1'($urandom), 7'($urandom), 1'($urandom), 8'($urandom), 8'($urandom), "R3");
      sweep("R4");

      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
   end

endmodule